// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block produces the data word returned for every read of an emulated parallel NOR flash. A command sequencer elsewhere supplies the current command code. From that code the block chooses among array bytes from storage, fixed identification words, a status byte whose bit 6 toggles on every read, and one byte of a query table held in an external constant ROM. Array reads are 1, 2 or 4 bytes wide, in little- or big-endian byte order. The identification and query lookups use a word index formed from the low address bits and the device width.

The block also counts reads made while the write sequencer is idle. Once more than a set number of such reads have occurred, it raises the fast array-read enable again. Any write clears that enable and the count. A command code the block does not recognise is served as a normal array read and also raises a one-cycle error pulse, so that the sequencer can reset. All read results are registered and are valid one clock after the read strobe.

Top module: `flash_read_mux`

## Requirements
- R1: With `rd_mode` 8'h00 (read) or 8'h80 (erase setup), the result is the array bytes `arr_bytes` (byte k in bits 8k+7:8k). `rd_size` 0 returns byte 0. Size 1 returns {b1,b0} little-endian or {b0,b1} when `rd_big`=1. Size 2 returns {b3,b2,b1,b0} or {b0,b1,b2,b3}. Unused upper bits are zero.
- R2: With `rd_mode` 8'h90 (identify), word index 0 returns ID_W0, index 1 returns ID_W1 and index 2 returns 0 (no sector protected). Each is zero-extended to 32 bits.
- R3: In identify mode, index 8'h0E returns ID_W2 and index 8'h0F returns ID_W3, unless that word's low byte is 8'hFF. In that case, and for every other index, the array result of R1 is returned.
- R4: With `rd_mode` 8'hA0, 8'h10 or 8'h30 (program, chip erase, sector erase), the result is {24'b0, status}, and bit 6 of the status inverts after each such read. `stat_load` writes `stat_value` into the status, and that write takes priority over the toggle in the same cycle.
- R5: With `rd_mode` 8'h98 (query), the result is {24'b0, `query_byte`} when the word index is below 82, and 0 otherwise. `query_idx` always carries the word index.
- R6: The word index is `rd_addr` shifted right by 0, 1 or 2 for DEV_BYTES of 1, 2 or 4. With the default of 2, address bit 0 is ignored.
- R7: `fast_mode` is 1 after reset. A `wr_en` cycle clears it and the read count. A read with `fast_mode`=0 and `wr_idle`=1 increments the count, and the read that takes the count above LAZY_LIMIT (42) sets `fast_mode` after that edge. Reads with `wr_idle`=0 are not counted.
- R8: Any other `rd_mode` value is served as an array read (R1), and `bad_state` is 1 for exactly the cycle in which that result is valid.
- R9: `rd_valid` is 1 exactly one clock after a cycle with `rd_en`, and `rd_data` changes only then. After reset `rd_valid`, `rd_data` and `bad_state` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Low byte of the read address |
| rd_size | input | 2 | Access size: 0=1, 1=2, 2=4 bytes |
| rd_big | input | 1 | Big-endian byte order |
| rd_mode | input | 8 | Current command code from the sequencer |
| arr_bytes | input | 32 | Four array bytes starting at the read offset |
| wr_idle | input | 1 | Write sequencer is in its idle cycle |
| wr_en | input | 1 | A write access occurred |
| stat_load | input | 1 | Load a new status byte |
| stat_value | input | 8 | Status byte to load |
| query_byte | input | 8 | Query ROM byte at `query_idx` |
| query_idx | output | 8 | Word index used for query ROM lookup |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| bad_state | output | 1 | Unknown command code pulse |
| fast_mode | output | 1 | Fast array-read mode enable |

## Verification
The bench targets the identify words at indexes 14 and 15. A design that skips the low-byte test there would return 16'h00FF instead of array data. It drives back-to-back status reads and a status load in the same cycle as a read, since a design that toggles on the wrong mode, or lets the toggle override the load, returns the wrong bit 6. It walks the read counter through 42 and 43 counted reads, mixed with uncounted busy reads, to expose an off-by-one or a counter that ignores `wr_idle`. It probes query indexes 81 and 82 and odd addresses, which catch a wrong bound or a wrong index shift.

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
  parameter int DEV_BYTES = 2,
  parameter logic [15:0] ID_W0 = 16'h0001,
  parameter logic [15:0] ID_W1 = 16'h227E,
  parameter logic [15:0] ID_W2 = 16'h2201,
  parameter logic [15:0] ID_W3 = 16'h00FF,
  parameter int LAZY_LIMIT = 42,
  parameter int QUERY_LEN = 82
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  input  logic [1:0]  rd_size,
  input  logic        rd_big,
  input  logic [7:0]  rd_mode,
  input  logic [31:0] arr_bytes,
  input  logic        wr_idle,
  input  logic        wr_en,
  input  logic        stat_load,
  input  logic [7:0]  stat_value,
  input  logic [7:0]  query_byte,
  output logic [7:0]  query_idx,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        bad_state,
  output logic        fast_mode
);
  localparam int SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam int CW = $clog2(LAZY_LIMIT + 2);

  logic [7:0]  status;
  logic [CW-1:0] cnt;
  logic [31:0] arr_word, resp;
  logic [15:0] id_hi;
  logic        unknown, status_rd;

  wire [7:0] b0 = arr_bytes[7:0];
  wire [7:0] b1 = arr_bytes[15:8];
  wire [7:0] b2 = arr_bytes[23:16];
  wire [7:0] b3 = arr_bytes[31:24];

  assign query_idx = rd_addr >> SHIFT;
  assign id_hi = query_idx[0] ? ID_W3 : ID_W2;

  always_comb begin
    case (rd_size)
      2'd0:    arr_word = {24'b0, b0};
      2'd1:    arr_word = rd_big ? {16'b0, b0, b1} : {16'b0, b1, b0};
      default: arr_word = rd_big ? {b0, b1, b2, b3} : arr_bytes;
    endcase
  end

  always_comb begin
    resp = arr_word;
    unknown = 1'b0;
    status_rd = 1'b0;
    case (rd_mode)
      8'h00, 8'h80: resp = arr_word;
      8'h90: begin
        if (query_idx == 8'h00)      resp = {16'b0, ID_W0};
        else if (query_idx == 8'h01) resp = {16'b0, ID_W1};
        else if (query_idx == 8'h02) resp = 32'b0;
        else if ((query_idx == 8'h0E || query_idx == 8'h0F) && id_hi[7:0] != 8'hFF)
          resp = {16'b0, id_hi};
      end
      8'hA0, 8'h10, 8'h30: begin
        resp = {24'b0, status};
        status_rd = 1'b1;
      end
      8'h98: resp = (query_idx < 8'(QUERY_LEN)) ? {24'b0, query_byte} : 32'b0;
      default: unknown = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      bad_state <= 1'b0;
    end else begin
      rd_valid  <= rd_en;
      bad_state <= rd_en & unknown;
      if (rd_en) rd_data <= resp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                status <= '0;
    else if (stat_load)        status <= stat_value;
    else if (rd_en && status_rd) status[6] <= ~status[6];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      fast_mode <= 1'b1;
    end else if (wr_en) begin
      cnt <= '0;
      fast_mode <= 1'b0;
    end else if (rd_en && !fast_mode && wr_idle) begin
      cnt <= cnt + 1'b1;
      if (cnt >= CW'(LAZY_LIMIT)) fast_mode <= 1'b1;
    end
  end
endmodule

module flash_read_mux_chk #(
  parameter int QUERY_LEN = 82
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  rd_mode,
  input logic [7:0]  query_idx,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        bad_state,
  input logic        fast_mode
);
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bad_state |-> rd_valid); // R8
  AST_WRITE_DROPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !fast_mode); // R7
  AST_FAST_RISES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_mode) |-> $past(rd_en)); // R7
  AST_QUERY_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_mode == 8'h98 && query_idx >= 8'(QUERY_LEN)) |=> rd_data == 32'b0); // R5
endmodule

bind flash_read_mux flash_read_mux_chk #(.QUERY_LEN(QUERY_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .rd_mode(rd_mode),
  .query_idx(query_idx), .rd_valid(rd_valid), .rd_data(rd_data),
  .bad_state(bad_state), .fast_mode(fast_mode));

// File: tb/tb_flash_read_mux.sv
`timescale 1ns/1ps
module tb_flash_read_mux;
  localparam logic [15:0] W0 = 16'h0001, W1 = 16'h227E, W2 = 16'h2201, W3 = 16'h00FF;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, rd_big = 0, wr_idle = 1, wr_en = 0, stat_load = 0;
  logic [7:0] rd_addr = 0, rd_mode = 0, stat_value = 0, query_byte, query_idx;
  logic [1:0] rd_size = 0;
  logic [31:0] arr_bytes = 0, rd_data;
  logic rd_valid, bad_state, fast_mode;

  int checks = 0, errors = 0;
  logic [7:0] m_status = 0;
  int m_cnt = 0;
  logic m_fast = 1;

  always #2.5 clk = ~clk;
  assign query_byte = query_idx ^ 8'h5A;

  flash_read_mux dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_arr(input logic [31:0] b, input logic [1:0] sz, input logic big);
    case (sz)
      2'd0: return {24'b0, b[7:0]};
      2'd1: return big ? {16'b0, b[7:0], b[15:8]} : {16'b0, b[15:0]};
      default: return big ? {b[7:0], b[15:8], b[23:16], b[31:24]} : b;
    endcase
  endfunction

  function automatic logic [31:0] exp_resp(input logic [7:0] mode, input logic [7:0] addr,
      input logic [31:0] b, input logic [1:0] sz, input logic big, input logic [7:0] st);
    logic [7:0] wi = addr >> 1;
    logic [31:0] a = exp_arr(b, sz, big);
    case (mode)
      8'h90: begin
        if (wi == 0) return {16'b0, W0};
        if (wi == 1) return {16'b0, W1};
        if (wi == 2) return 0;
        if (wi == 8'h0E && W2[7:0] != 8'hFF) return {16'b0, W2};
        if (wi == 8'h0F && W3[7:0] != 8'hFF) return {16'b0, W3};
        return a;
      end
      8'hA0, 8'h10, 8'h30: return {24'b0, st};
      8'h98: return (wi < 82) ? {24'b0, wi ^ 8'h5A} : 0;
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] mode);
    case (mode)
      8'h00, 8'h80: return "R1";
      8'h90: return "R2/R3";
      8'hA0, 8'h10, 8'h30: return "R4";
      8'h98: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic do_read(input logic [7:0] mode, input logic [7:0] addr, input logic [31:0] b,
                         input logic [1:0] sz, input logic big, input logic idle, input string tag);
    logic [31:0] e;
    bit unk;
    e = exp_resp(mode, addr, b, sz, big, m_status);
    unk = !(mode inside {8'h00, 8'h80, 8'h90, 8'hA0, 8'h10, 8'h30, 8'h98});
    rd_en = 1; rd_mode = mode; rd_addr = addr; arr_bytes = b; rd_size = sz; rd_big = big; wr_idle = idle;
    @(posedge clk); #1;
    rd_en = 0; wr_idle = 1;
    if (mode inside {8'hA0, 8'h10, 8'h30}) m_status[6] = ~m_status[6];
    if (!m_fast && idle) begin
      m_cnt++;
      if (m_cnt > 42) m_fast = 1;
    end
    chk(rd_valid === 1'b1, "R9 valid", {31'b0, rd_valid}, 1);
    chk(rd_data === e, tag, rd_data, e);
    chk(bad_state === unk, "R8 err pulse", {31'b0, bad_state}, {31'b0, unk});
    chk(fast_mode === m_fast, "R7 fast", {31'b0, fast_mode}, {31'b0, m_fast});
  endtask

  task automatic do_write();
    wr_en = 1; @(posedge clk); #1; wr_en = 0;
    m_cnt = 0; m_fast = 0;
    chk(fast_mode === 1'b0, "R7 write clears", {31'b0, fast_mode}, 0);
  endtask

  task automatic do_load(input logic [7:0] v);
    stat_load = 1; stat_value = v; @(posedge clk); #1; stat_load = 0;
    m_status = v;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(rd_valid === 0 && rd_data === 0 && bad_state === 0, "R9 reset", rd_data, 0);
    chk(fast_mode === 1, "R7 reset fast", {31'b0, fast_mode}, 1);
    // R1 array assembly
    do_read(8'h00, 8'h10, 32'h44332211, 2'd1, 0, 1, "R1 16 LE");
    do_read(8'h00, 8'h10, 32'h44332211, 2'd1, 1, 1, "R1 16 BE");
    do_read(8'h00, 8'h11, 32'h44332211, 2'd0, 1, 1, "R1 8");
    do_read(8'h80, 8'h10, 32'h44332211, 2'd2, 1, 1, "R1 32 BE erase setup");
    do_read(8'h00, 8'h10, 32'h44332211, 2'd2, 0, 1, "R1 32 LE");
    // R2, R3, R6
    do_read(8'h90, 8'h00, 32'hDEADBEEF, 2'd1, 0, 1, "R2 idx0");
    do_read(8'h90, 8'h02, 32'hDEADBEEF, 2'd1, 0, 1, "R2 idx1");
    do_read(8'h90, 8'h04, 32'hDEADBEEF, 2'd1, 0, 1, "R2 idx2");
    do_read(8'h90, 8'h03, 32'hDEADBEEF, 2'd1, 0, 1, "R6 odd addr idx1");
    do_read(8'h90, 8'h1C, 32'hDEADBEEF, 2'd1, 0, 1, "R3 idx E");
    do_read(8'h90, 8'h1E, 32'hDEADBEEF, 2'd1, 0, 1, "R3 idx F fallback");
    do_read(8'h90, 8'h06, 32'hDEADBEEF, 2'd2, 0, 1, "R3 other idx");
    // R4 status
    do_load(8'h80);
    do_read(8'hA0, 8'h00, 0, 2'd0, 0, 1, "R4 status first");
    do_read(8'hA0, 8'h00, 0, 2'd0, 0, 1, "R4 status toggled");
    do_read(8'h10, 8'h00, 0, 2'd0, 0, 1, "R4 chip erase status");
    do_read(8'h00, 8'h00, 32'h5, 2'd0, 0, 1, "R4 read mode no toggle");
    do_read(8'h30, 8'h00, 0, 2'd0, 0, 1, "R4 sector erase status");
    stat_load = 1; stat_value = 8'h11;
    do_read(8'h30, 8'h00, 0, 2'd0, 0, 1, "R4 load with read");
    stat_load = 0; m_status = 8'h11;
    do_read(8'h30, 8'h00, 0, 2'd0, 0, 1, "R4 load wins");
    // R5 query
    do_read(8'h98, 8'h20, 0, 2'd0, 0, 1, "R5 idx 0x10");
    do_read(8'h98, 8'hA2, 0, 2'd0, 0, 1, "R5 idx 81");
    do_read(8'h98, 8'hA4, 0, 2'd0, 0, 1, "R5 idx 82 zero");
    chk(query_idx === 8'h52, "R6 query_idx", {24'b0, query_idx}, 32'h52);
    // R8 unknown
    do_read(8'h42, 8'h00, 32'hCAFEF00D, 2'd2, 0, 1, "R8 unknown as array");
    @(posedge clk); #1;
    chk(bad_state === 0 && rd_valid === 0, "R8 R9 pulse ends", {31'b0, bad_state}, 0);
    // R7 counter
    do_write();
    for (int i = 0; i < 5; i++) do_read(8'h00, 8'h00, 0, 2'd0, 0, 0, "R7 busy read");
    for (int i = 0; i < 42; i++) do_read(8'h00, 8'h00, 0, 2'd0, 0, 1, "R7 count");
    chk(fast_mode === 0, "R7 at 42", {31'b0, fast_mode}, 0);
    do_read(8'h00, 8'h00, 0, 2'd0, 0, 1, "R7 43rd");
    chk(fast_mode === 1, "R7 after 43", {31'b0, fast_mode}, 1);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] modes [8] = '{8'h00, 8'h80, 8'h90, 8'hA0, 8'h10, 8'h30, 8'h98, 8'h42};
      int r = $urandom % 20;
      if (r == 0) do_write();
      else if (r == 1) do_load(8'($urandom));
      else begin
        logic [7:0] m = modes[$urandom % 8];
        logic [7:0] a = ($urandom % 2) ? 8'($urandom % 40) : 8'($urandom);
        do_read(m, a, $urandom, 2'($urandom % 3), 1'($urandom), 1'(($urandom % 4) != 0), tag_of(m));
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule